// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Overflow Flag

This unit performs 32-bit arithmetic that clamps instead of wrapping. It covers signed and unsigned add and subtract, clamping a single word to a chosen bit width, and packed forms that clamp the two 16-bit halves of a word independently of each other. A variant of signed add returns the wrapped sum but still records the overflow. The result path is purely combinational: the result is valid in the same cycle as the operands.

Every clamp event that happens while `op_valid` is high sets a sticky flag on the next rising clock edge. The flag stays set through any number of later non-clamping operations. It is cleared only by `q_clear`, which wins over a set in the same cycle. The surrounding datapath reads the flag to learn whether any result since the last clear lost precision.

Top module: `sat_alu`

## Requirements
- R1: After reset, `q_flag` is 0.
- R2: Operation code 1 (signed add) returns the sum. If both operands share a sign and the raw sum's sign differs, it returns 0x7FFFFFFF when `opa` is non-negative and 0x80000000 when `opa` is negative, and this counts as a clamp event.
- R3: Operation code 2 (signed subtract) returns `opa - opb`. If the operands differ in sign and the raw difference's sign differs from `opa`'s sign, it clamps with the same rule as R2, and this counts as a clamp event.
- R4: Operation code 3 (unsigned add) returns 0xFFFFFFFF, as a clamp event, when the 32-bit sum wraps. Otherwise it returns the sum.
- R5: Operation code 4 (unsigned subtract) returns 0, as a clamp event, when `opb > opa`. Otherwise it returns the difference.
- R6: Operation code 5 (signed width clamp) takes n = `sat_width`. If `opa` shifted arithmetically right by n is above 0, it returns 2^n-1. If that value is below -1, it returns the complement of 2^n-1. Both of these are clamp events. Otherwise it returns `opa` unchanged.
- R7: Operation code 6 (unsigned width clamp) takes n = `sat_width`. It returns 0 for a negative `opa` and 2^n-1 for `opa` above 2^n-1, both as clamp events. Otherwise it returns `opa` unchanged.
- R8: Operation codes 7 (signed) and 8 (unsigned) apply the rules of R6 and R7 to bits 15:0 and 31:16 of `opa` separately. Each half is taken as a signed 16-bit value, and n = `sat_width[3:0]`. The two 16-bit results are packed in place. A clamp in either half is a clamp event.
- R9: Operation code 0 returns the wrapped 32-bit sum, and the signed overflow condition of R2 counts as a clamp event.
- R10: `q_flag` becomes 1 on the clock edge at which `op_valid` is 1 and the current operation clamps. With `op_valid` at 0 the flag is not set, although `result` is still computed.
- R11: `q_flag` stays 1 until a cycle with `q_clear` at 1. That cycle clears it, even if a clamp event with `op_valid` occurs in the same cycle.
- R12: Operation codes 9 to 15 return 0 and are never clamp events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation is live; allows a clamp event to set the flag |
| op_code | input | 4 | Operation select (codes in R2 to R12) |
| opa | input | 32 | First operand, and the value that the width clamps act on |
| opb | input | 32 | Second operand for add and subtract |
| sat_width | input | 5 | Clamp width n for codes 5 to 8 |
| q_clear | input | 1 | Synchronous clear of the sticky flag |
| result | output | 32 | Combinational result |
| q_flag | output | 1 | Sticky clamp flag |

## Verification
The bench targets the overflow boundaries. It adds one to the largest positive word and subtracts one from the most negative word. A design that tested the result's sign without looking at the operand signs would flag 5 + (-3) or return a wrapped value. The width clamps are tested at n = 0, where 1 must become 0 and -1 must pass, and at values exactly on the range edge (-128 and 255). An off-by-one range rule would clamp these. The packed forms are driven with only one half out of range, which catches a design that shares a clamp decision across halves or fails to sign-extend the upper half. The flag tests check that the flag survives a clean operation, that it ignores a clamp made without `op_valid`, and that a clear beats a simultaneous set.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD_WRAPQ = 4'd0,
        OP_SADD      = 4'd1,
        OP_SSUB      = 4'd2,
        OP_UADD      = 4'd3,
        OP_USUB      = 4'd4,
        OP_SCLAMP    = 4'd5,
        OP_UCLAMP    = 4'd6,
        OP_SCLAMP2   = 4'd7,
        OP_UCLAMP2   = 4'd8
    } sat_op_e;

    typedef struct packed {
        logic sticky;
    } sat_state_t;

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  sat_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           sat
);
    localparam int MSB = W - 1;

    logic [W:0]   sum_ext;
    logic [W-1:0] diff;
    logic [W-1:0] s_limit;
    logic         s_add_ovf;
    logic         s_sub_ovf;

    always_comb begin
        sum_ext   = {1'b0, a} + {1'b0, b};
        diff      = a - b;
        s_limit   = a[MSB] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        s_add_ovf = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
        s_sub_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
        res = sum_ext[W-1:0];
        sat = 1'b0;
        case (op)
            OP_ADD_WRAPQ: begin
                res = sum_ext[W-1:0];
                sat = s_add_ovf;
            end
            OP_SADD: begin
                res = s_add_ovf ? s_limit : sum_ext[W-1:0];
                sat = s_add_ovf;
            end
            OP_SSUB: begin
                res = s_sub_ovf ? s_limit : diff;
                sat = s_sub_ovf;
            end
            OP_UADD: begin
                res = sum_ext[W] ? {W{1'b1}} : sum_ext[W-1:0];
                sat = sum_ext[W];
            end
            OP_USUB: begin
                res = (b > a) ? '0 : diff;
                sat = (b > a);
            end
            default: begin
                res = '0;
                sat = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int W   = 32,
    localparam int N_W = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [N_W-1:0] n,
    input  logic           is_signed,
    output logic [W-1:0]   res,
    output logic           sat
);
    logic [W-1:0]        lim;
    logic signed [W-1:0] top;

    always_comb begin
        lim = (W'(1) << n) - W'(1);
        top = $signed(val) >>> n;
        res = val;
        sat = 1'b0;
        if (is_signed) begin
            if (top > 0) begin
                res = lim;
                sat = 1'b1;
            end else if (top < -1) begin
                res = ~lim;
                sat = 1'b1;
            end
        end else begin
            if (val[W-1]) begin
                res = '0;
                sat = 1'b1;
            end else if (val > lim) begin
                res = lim;
                sat = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2,
    localparam int NW_W   = $clog2(DATA_W),
    localparam int NH_W   = $clog2(HALF_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [NW_W-1:0]   sat_width,
    input  logic              q_clear,
    output logic [DATA_W-1:0] result,
    output logic              q_flag
);
    sat_op_e    op;
    sat_state_t st_d, st_q;

    logic [DATA_W-1:0]            as_res, w_res;
    logic                         as_sat, w_sat;
    logic [1:0][HALF_W-1:0]       h_res;
    logic [1:0]                   h_sat;
    logic [DATA_W-1:0]            res_d;
    logic                         evt_d;

    assign op = sat_op_e'(op_code);

    sat_addsub #(.W(DATA_W)) i_addsub (
        .op  (op),
        .a   (opa),
        .b   (opb),
        .res (as_res),
        .sat (as_sat)
    );

    sat_clamp #(.W(DATA_W)) i_word_clamp (
        .val       (opa),
        .n         (sat_width),
        .is_signed (op == OP_SCLAMP),
        .res       (w_res),
        .sat       (w_sat)
    );

    for (genvar g = 0; g < 2; g++) begin : g_half
        sat_clamp #(.W(HALF_W)) i_half_clamp (
            .val       (opa[g*HALF_W +: HALF_W]),
            .n         (sat_width[NH_W-1:0]),
            .is_signed (op == OP_SCLAMP2),
            .res       (h_res[g]),
            .sat       (h_sat[g])
        );
    end

    always_comb begin
        st_d  = st_q;
        res_d = '0;
        evt_d = 1'b0;
        case (op)
            OP_ADD_WRAPQ, OP_SADD, OP_SSUB, OP_UADD, OP_USUB: begin
                res_d = as_res;
                evt_d = as_sat;
            end
            OP_SCLAMP, OP_UCLAMP: begin
                res_d = w_res;
                evt_d = w_sat;
            end
            OP_SCLAMP2, OP_UCLAMP2: begin
                res_d = h_res;
                evt_d = |h_sat;
            end
            default: begin
                res_d = '0;
                evt_d = 1'b0;
            end
        endcase
        if (q_clear) begin
            st_d.sticky = 1'b0;
        end else if (op_valid && evt_d) begin
            st_d.sticky = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = res_d;
    assign q_flag = st_q.sticky;
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   op_code,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         q_clear,
    input logic [W-1:0] result,
    input logic         q_flag
);
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        q_clear |=> !q_flag); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q_flag && !q_clear) |=> q_flag); // R11
    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_flag && !op_valid) |=> !q_flag); // R10
    AST_UADD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd3) |-> (result >= opa)); // R4
    AST_USUB_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd4) |-> (result <= opa)); // R5
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > 4'd8) |-> (result == '0)); // R12
    AST_WRAPQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !q_clear && op_code == 4'd0 && opa[W-1] == opb[W-1]
         && result[W-1] != opa[W-1]) |=> q_flag); // R9
endmodule

bind sat_alu sat_alu_chk #(.W(32)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .opa      (opa),
    .opb      (opb),
    .q_clear  (q_clear),
    .result   (result),
    .q_flag   (q_flag)
);

// File: tb/test_sat_alu.sv
module test_sat_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  sat_width = '0;
    logic        q_clear = 1'b0;
    logic [31:0] result;
    logic        q_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sat_alu i_sat_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opa(opa), .opb(opb), .sat_width(sat_width), .q_clear(q_clear),
        .result(result), .q_flag(q_flag)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        op_valid = 1'b0;
        q_clear  = 1'b1;
        @(negedge clk);
        q_clear  = 1'b0;
    endtask

    // Clear, apply one valid operation, check result and resulting flag.
    task automatic run_op(string req, logic [3:0] op, logic [31:0] a,
                          logic [31:0] b, logic [4:0] n,
                          logic [31:0] exp_res, logic exp_q);
        clear_flag();
        op_code = op; opa = a; opb = b; sat_width = n; op_valid = 1'b1;
        #1 check(req, result, exp_res);
        @(posedge clk);
        #1 check(req, {31'd0, q_flag}, {31'd0, exp_q});
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", {31'd0, q_flag}, 32'd0);
    endtask

    task automatic t_sadd();
        run_op("R2", 4'd1, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h7FFFFFFF, 1'b1);
        run_op("R2", 4'd1, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1);
        run_op("R2", 4'd1, 32'h00000005, 32'hFFFFFFFD, 5'd0, 32'h00000002, 1'b0);
    endtask

    task automatic t_ssub();
        run_op("R3", 4'd2, 32'h80000000, 32'h00000001, 5'd0, 32'h80000000, 1'b1);
        run_op("R3", 4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1);
        run_op("R3", 4'd2, 32'd10, 32'd3, 5'd0, 32'd7, 1'b0);
    endtask

    task automatic t_uadd();
        run_op("R4", 4'd3, 32'hFFFFFFF0, 32'h20, 5'd0, 32'hFFFFFFFF, 1'b1);
        run_op("R4", 4'd3, 32'd1, 32'd2, 5'd0, 32'd3, 1'b0);
    endtask

    task automatic t_usub();
        run_op("R5", 4'd4, 32'd3, 32'd5, 5'd0, 32'd0, 1'b1);
        run_op("R5", 4'd4, 32'd5, 32'd3, 5'd0, 32'd2, 1'b0);
        run_op("R5", 4'd4, 32'd5, 32'd5, 5'd0, 32'd0, 1'b0);
    endtask

    task automatic t_sclamp();
        run_op("R6", 4'd5, 32'd200, 32'd0, 5'd7, 32'd127, 1'b1);
        run_op("R6", 4'd5, 32'hFFFFFED4, 32'd0, 5'd7, 32'hFFFFFF80, 1'b1);
        run_op("R6", 4'd5, 32'hFFFFFF80, 32'd0, 5'd7, 32'hFFFFFF80, 1'b0);
        run_op("R6", 4'd5, 32'd1, 32'd0, 5'd0, 32'd0, 1'b1);
        run_op("R6", 4'd5, 32'hFFFFFFFF, 32'd0, 5'd0, 32'hFFFFFFFF, 1'b0);
    endtask

    task automatic t_uclamp();
        run_op("R7", 4'd6, 32'd300, 32'd0, 5'd8, 32'd255, 1'b1);
        run_op("R7", 4'd6, 32'hFFFFFFFF, 32'd0, 5'd8, 32'd0, 1'b1);
        run_op("R7", 4'd6, 32'd255, 32'd0, 5'd8, 32'd255, 1'b0);
        run_op("R7", 4'd6, 32'h7FFFFFFF, 32'd0, 5'd31, 32'h7FFFFFFF, 1'b0);
    endtask

    task automatic t_dual();
        run_op("R8", 4'd7, 32'hFF000100, 32'd0, 5'd7, 32'hFF80007F, 1'b1);
        run_op("R8", 4'd7, 32'h0005FFFE, 32'd0, 5'd7, 32'h0005FFFE, 1'b0);
        run_op("R8", 4'd7, 32'h00100200, 32'd0, 5'd7, 32'h0010007F, 1'b1);
        run_op("R8", 4'd7, 32'h80007FFF, 32'd0, 5'd15, 32'h80007FFF, 1'b0);
        run_op("R8", 4'd8, 32'h80000123, 32'd0, 5'd8, 32'h000000FF, 1'b1);
        run_op("R8", 4'd8, 32'h00FF0010, 32'd0, 5'd24, 32'h00FF0010, 1'b0);
    endtask

    task automatic t_wrapq();
        run_op("R9", 4'd0, 32'h7FFFFFFF, 32'd1, 5'd0, 32'h80000000, 1'b1);
        run_op("R9", 4'd0, 32'd1, 32'd1, 5'd0, 32'd2, 1'b0);
    endtask

    task automatic t_idle();
        clear_flag();
        op_code = 4'd1; opa = 32'h7FFFFFFF; opb = 32'd1; op_valid = 1'b0;
        #1 check("R10", result, 32'h7FFFFFFF);
        @(posedge clk);
        #1 check("R10", {31'd0, q_flag}, 32'd0);
    endtask

    task automatic t_sticky();
        run_op("R11", 4'd3, 32'hFFFFFFFF, 32'd1, 5'd0, 32'hFFFFFFFF, 1'b1);
        op_code = 4'd3; opa = 32'd1; opb = 32'd1; op_valid = 1'b1;
        @(posedge clk);
        #1 check("R11", {31'd0, q_flag}, 32'd1);
        @(negedge clk);
        op_valid = 1'b0;
        @(posedge clk);
        #1 check("R11", {31'd0, q_flag}, 32'd1);
        @(negedge clk);
        opa = 32'hFFFFFFFF; op_valid = 1'b1; q_clear = 1'b1;
        @(posedge clk);
        #1 check("R11", {31'd0, q_flag}, 32'd0);
        @(negedge clk);
        op_valid = 1'b0; q_clear = 1'b0;
    endtask

    task automatic t_unused();
        for (int c = 9; c < 16; c++) begin
            run_op("R12", 4'(c), 32'h7FFFFFFF, 32'd1, 5'd0, 32'd0, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1 t_reset();
        t_sadd();
        t_ssub();
        t_uadd();
        t_usub();
        t_sclamp();
        t_uclamp();
        t_dual();
        t_wrapq();
        t_idle();
        t_sticky();
        t_unused();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule